// File: doc/BRIEF.md
# Serial EEPROM Command Responder

This block behaves as the device side of a small three-wire serial EEPROM with 128 words of 16 bits. A host lowers an active-low chip select, drives a data bit while the serial clock is low, and raises the serial clock to hand that bit over. Each transaction opens with an address byte and then a command byte, both least significant bit first. The command then either moves one 16-bit word in or out, or takes effect at once: erase everything, set the write-protect latch, or clear it.

The serial pins are sampled by the system clock. A rising edge of the serial clock is found by comparing its level with the level seen one system cycle earlier. The reply bit is a registered output. When a command has finished, the block waits for a new address byte. The host can release chip select between transactions, but it does not have to. Releasing chip select at any point drops the transaction that is in progress.

Top module: `eep_responder`

## Requirements
- R1: After reset, `sdo` is 1, writes are enabled, and every word reads 0xFFFF.
- R2: While `cs_n` is high, the bit count and the phase return to the address phase and `sdo` is 1. A write whose last data edge comes in the same system cycle as `cs_n` going high is not stored.
- R3: On each rising `sclk` edge with `cs_n` low, `sdi` is taken. The first 8 bits of a transaction form the address, least significant bit first. Only address bits 6..0 select the word, and bit 7 is ignored.
- R4: The next 8 bits form the command code, least significant bit first. The code is decoded on the 16th rising edge of the transaction.
- R5: For code 0x01 (read), `sdo` shows word bit 0 after the 16th edge. Each of the next 15 rising edges advances `sdo` to the next higher bit. The 16th data edge returns `sdo` to 1.
- R6: For code 0x06 (write), the next 16 bits are shifted in, least significant bit first. The word is stored at the address only if the write-enable latch is set.
- R7: Code 0x09 sets the write-enable latch and code 0x0B clears it. The latch keeps its value when `cs_n` goes high.
- R8: Code 0x0C sets all 128 words to 0xFFFF, whatever the state of the latch.
- R9: Code 0x0D and any code not listed in R5 to R8 change no stored word and do not change the latch. `sdo` stays 1.
- R10: After any command completes, a new address byte can follow without releasing `cs_n`.
- R11: `sdo` changes only on a rising `sclk` edge or when `cs_n` is high. It is 1 outside the read data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, sampled by `clk` |
| sdi | input | 1 | Serial data into the device |
| sdo | output | 1 | Serial data out of the device, registered |

## Verification
The commit of a written word and the abort on chip-select release can fall in the same system cycle: the final data edge of a write and the release of `cs_n`. The bench sets up this case by raising `sclk` and `cs_n` on the same system clock. It then reads the address back and expects the word that was stored before. A second abort in the middle of an address byte is judged by the next full transaction decoding its address from bit 0.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_CMD   = 2'd1,
    PH_READ  = 2'd2,
    PH_WRITE = 2'd3
  } phase_e;

  localparam logic [7:0] OP_READ  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h06;
  localparam logic [7:0] OP_WEN   = 8'h09;
  localparam logic [7:0] OP_WDIS  = 8'h0B;
  localparam logic [7:0] OP_ERASE = 8'h0C;
  localparam logic [7:0] OP_NOP   = 8'h0D;
endpackage

// File: rtl/eep_store.sv
module eep_store #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 128,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              erase,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rdata
);
  // Array without reset so it maps onto block RAM; erase is a flag vector.
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] mem_q;
  logic [DEPTH-1:0]  blank;
  logic              blank_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    mem_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || erase) begin
      blank   <= '1;
      blank_q <= 1'b1;
    end else begin
      if (wr_en) blank[wr_addr] <= 1'b0;
      blank_q <= blank[rd_addr];
    end
  end

  assign rdata = blank_q ? '1 : mem_q;
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic [WORD_W-1:0] rdata,
  output logic [AW-1:0]     rd_addr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              erase,
  output logic              sdo
);
  localparam int CW = $clog2(WORD_W);
  localparam logic [CW-1:0] BYTE_LAST = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] WORD_LAST = CW'(WORD_W - 1);

  phase_e            phase;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] addr_sh, cmd_sh;
  logic [WORD_W-1:0] data_sh;
  logic              we_latch;
  logic              sclk_q;
  logic              rise;
  logic [BYTE_W-1:0] cmd_next;
  logic [WORD_W-1:0] data_next;

  assign rise      = sclk & ~sclk_q;
  assign cmd_next  = {sdi, cmd_sh[BYTE_W-1:1]};
  assign data_next = {sdi, data_sh[WORD_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b1;
    else     sclk_q <= sclk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_ADDR;
      cnt      <= '0;
      addr_sh  <= '0;
      cmd_sh   <= '0;
      data_sh  <= '0;
      we_latch <= 1'b1;
      sdo      <= 1'b1;
      wr_en    <= 1'b0;
      erase    <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      erase <= 1'b0;
      if (cs_n) begin
        phase <= PH_ADDR;
        cnt   <= '0;
        sdo   <= 1'b1;
      end else if (rise) begin
        cnt <= cnt + 1'b1;
        unique case (phase)
          PH_ADDR: begin
            addr_sh <= {sdi, addr_sh[BYTE_W-1:1]};
            if (cnt == BYTE_LAST) begin
              phase <= PH_CMD;
              cnt   <= '0;
            end
          end
          PH_CMD: begin
            cmd_sh <= cmd_next;
            if (cnt == BYTE_LAST) begin
              cnt   <= '0;
              phase <= PH_ADDR;
              case (cmd_next)
                OP_READ: begin
                  phase   <= PH_READ;
                  data_sh <= rdata;
                  sdo     <= rdata[0];
                end
                OP_WRITE: phase    <= PH_WRITE;
                OP_ERASE: erase    <= 1'b1;
                OP_WEN:   we_latch <= 1'b1;
                OP_WDIS:  we_latch <= 1'b0;
                default: ; // no-op and unknown codes: back to address phase
              endcase
            end
          end
          PH_READ: begin
            data_sh <= data_sh >> 1;
            sdo     <= data_sh[1];
            if (cnt == WORD_LAST) begin
              phase <= PH_ADDR;
              cnt   <= '0;
              sdo   <= 1'b1;
            end
          end
          PH_WRITE: begin
            data_sh <= data_next;
            if (cnt == WORD_LAST) begin
              phase <= PH_ADDR;
              cnt   <= '0;
              wr_en <= we_latch;
            end
          end
        endcase
      end
    end
  end

  assign rd_addr = addr_sh[AW-1:0];
  assign wr_addr = addr_sh[AW-1:0];
  assign wr_data = data_sh;
endmodule

// File: rtl/eep_responder.sv
module eep_responder #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 128,
  parameter int BYTE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0]     st_rd_addr, st_wr_addr;
  logic [WORD_W-1:0] st_wr_data, st_rdata;
  logic              st_wr_en, st_erase;

  eep_ctrl #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .AW(AW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .sdi     (sdi),
    .rdata   (st_rdata),
    .rd_addr (st_rd_addr),
    .wr_en   (st_wr_en),
    .wr_addr (st_wr_addr),
    .wr_data (st_wr_data),
    .erase   (st_erase),
    .sdo     (sdo)
  );

  eep_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (st_wr_en),
    .wr_addr (st_wr_addr),
    .wr_data (st_wr_data),
    .erase   (st_erase),
    .rd_addr (st_rd_addr),
    .rdata   (st_rdata)
  );
endmodule

// File: rtl/eep_responder_chk.sv
module eep_responder_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              sclk,
  input logic              sdo,
  input logic              wr_en,
  input logic              erase,
  input logic [WORD_W-1:0] rdata
);
  AST_RESET_SDO_HIGH: assert property (@(posedge clk) $fell(rst) |-> sdo); // R1
  AST_IDLE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst) cs_n |=> sdo); // R2
  AST_ABORT_BLOCKS_STORE: assert property (@(posedge clk) disable iff (rst) cs_n |=> !wr_en); // R2
  AST_ERASE_SINGLE: assert property (@(posedge clk) disable iff (rst) erase |=> !erase); // R8
  AST_ERASE_BLANKS: assert property (@(posedge clk) disable iff (rst) erase |-> ##2 (rdata == '1)); // R8
  AST_SDO_HOLDS: assert property (@(posedge clk) disable iff (rst) (!cs_n && $stable(sclk)) |=> $stable(sdo)); // R11
endmodule

bind eep_responder eep_responder_chk #(.WORD_W(WORD_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .cs_n  (cs_n),
  .sclk  (sclk),
  .sdo   (sdo),
  .wr_en (st_wr_en),
  .erase (st_erase),
  .rdata (st_rdata)
);

// File: tb/tb_eep_responder.sv
module tb_eep_responder;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic sdi = 1'b0;
  logic sdo;
  int   n_checks = 0;
  int   n_fail   = 0;

  eep_responder dut (.clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    sclk = 1'b0; sdi = b;
    wait_clk(HALF);
    sclk = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_bit(v[i]);
  endtask

  task automatic sel();
    cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic desel();
    cs_n = 1'b1; wait_clk(HALF);
  endtask

  // Body of a write, chip select handled by caller.
  task automatic wr_body(input logic [7:0] a, input logic [15:0] d);
    put_byte(a); put_byte(8'h06);
    for (int i = 0; i < 16; i++) put_bit(d[i]);
  endtask

  task automatic rd_body(input logic [7:0] a, output logic [15:0] w);
    put_byte(a);
    check("R11 sdo idle in header", {15'd0, sdo}, 16'd1);
    put_byte(8'h01);
    for (int i = 0; i < 16; i++) begin
      w[i] = sdo;
      put_bit(1'b0);
    end
    check("R5 sdo back to idle", {15'd0, sdo}, 16'd1);
  endtask

  task automatic op_body(input logic [7:0] code);
    put_byte(8'h00); put_byte(code);
  endtask

  task automatic write_word(input logic [7:0] a, input logic [15:0] d);
    sel(); wr_body(a, d); desel();
  endtask

  task automatic read_word(input logic [7:0] a, output logic [15:0] w);
    sel(); rd_body(a, w); desel();
  endtask

  task automatic one_op(input logic [7:0] code);
    sel(); op_body(code); desel();
  endtask

  task automatic t_reset();
    logic [15:0] w;
    check("R1 sdo after reset", {15'd0, sdo}, 16'd1);
    read_word(8'h05, w);
    check("R1 blank word", w, 16'hFFFF);
  endtask

  task automatic t_write_read();
    logic [15:0] w;
    write_word(8'h00, 16'h1234);
    write_word(8'h7F, 16'hA5C3);
    write_word(8'h2A, 16'h0001);
    read_word(8'h00, w); check("R6 R5 addr 00", w, 16'h1234);
    read_word(8'h7F, w); check("R4 R5 addr 7F", w, 16'hA5C3);
    read_word(8'h2A, w); check("R3 R6 addr 2A", w, 16'h0001);
  endtask

  task automatic t_addr_msb();
    logic [15:0] w;
    write_word(8'h85, 16'hBEEF);
    read_word(8'h05, w); check("R3 address bit 7 ignored", w, 16'hBEEF);
  endtask

  task automatic t_back_to_back();
    logic [15:0] w;
    sel();
    wr_body(8'h10, 16'h5A5A);
    rd_body(8'h10, w);
    desel();
    check("R10 read after write in one select", w, 16'h5A5A);
  endtask

  task automatic t_protect();
    logic [15:0] w;
    sel(); op_body(8'h0B); wr_body(8'h00, 16'h0F0F); rd_body(8'h00, w); desel();
    check("R7 write ignored when disabled", w, 16'h1234);
    write_word(8'h00, 16'h0000);
    read_word(8'h00, w); check("R7 latch kept across deselect", w, 16'h1234);
    one_op(8'h09);
    write_word(8'h00, 16'h4321);
    read_word(8'h00, w); check("R7 R6 write after enable", w, 16'h4321);
  endtask

  task automatic t_nop_unknown();
    logic [15:0] w;
    sel(); op_body(8'h0D);
    check("R9 sdo after no-op", {15'd0, sdo}, 16'd1);
    rd_body(8'h7F, w); desel();
    check("R9 data after no-op", w, 16'hA5C3);
    sel(); op_body(8'h55);
    check("R9 sdo after unknown code", {15'd0, sdo}, 16'd1);
    rd_body(8'h7F, w); desel();
    check("R9 data after unknown code", w, 16'hA5C3);
    write_word(8'h7E, 16'h0C0C);
    read_word(8'h7E, w); check("R9 latch still enabled", w, 16'h0C0C);
  endtask

  task automatic t_abort();
    logic [15:0] w;
    sel();
    put_byte(8'h2A); put_byte(8'h06);
    for (int i = 0; i < 15; i++) put_bit(1'b1);
    sclk = 1'b0; sdi = 1'b1; wait_clk(HALF);
    sclk = 1'b1; cs_n = 1'b1; wait_clk(2 * HALF);
    check("R2 sdo while deselected", {15'd0, sdo}, 16'd1);
    read_word(8'h2A, w); check("R2 abort on final edge stores nothing", w, 16'h0001);
    sel(); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); desel();
    read_word(8'h7F, w); check("R2 counter restarts after abort", w, 16'hA5C3);
  endtask

  task automatic t_erase();
    logic [15:0] w;
    int bad = 0;
    one_op(8'h0B);
    one_op(8'h0C);
    for (int a = 0; a < 128; a++) begin
      read_word(8'(a), w);
      if (w !== 16'hFFFF) bad++;
      check("R8 word blank after erase", w, 16'hFFFF);
    end
    check("R8 count of non-blank words", 16'(bad), 16'd0);
    one_op(8'h09);
  endtask

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    t_write_read();
    t_addr_msb();
    t_back_to_back();
    t_protect();
    t_nop_unknown();
    t_abort();
    t_erase();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule